// File: doc/BRIEF.md
# Memory-Mapped UART Register Front End

This block sits between a processor's APB bus and a UART and holds the UART's registers. Four word registers are decoded from the low eight address bits: a data register, a read-only status register, a control register and a scaler register that reads as zero. Bytes arriving on a byte-wide receive input are queued in a receive FIFO when reception is enabled. A read of the data register pops the oldest byte from that FIFO. A write to the data register hands its low byte to a valid/ready transmit output when transmission is enabled.

A single interrupt line gives a one-cycle pulse when a byte is stored or sent. Each of those two causes has its own enable bit in the control register. The transmitter is treated as draining at once, so its two "empty" status flags are always set. The serial bit timing, the baud divider, parity, flow control and FIFO debug access all live outside this block.

Top module: `apb_uart_front`

## Requirements
- R1: Every APB transfer completes with no wait state: `pready` is always 1 and `pslverr` is always 0. A register write takes effect on the clock edge of the access phase.
- R2: Only `paddr[7:0]` is decoded. Offset 0x00 selects data and offset 0x03 is an alias of data. Status is at 0x04, control at 0x08 and scaler at 0x0C. The scaler reads 0 and ignores writes. Every other offset reads 0.
- R3: After reset, status reads 0x6, control reads 0, the receive FIFO is empty, and `irq` and `tx_valid` are 0.
- R4: Control bits 12:0 read back exactly as written, and bits 31:13 read 0. The bits this block acts on are: bit 0 receive enable, bit 1 transmit enable, bit 2 receive interrupt enable and bit 3 transmit interrupt enable.
- R5: A byte on `rx_data` with `rx_valid` high is stored only when control bit 0 is set. Storing it sets status bit 0 (data ready). When control bit 0 is clear, the byte has no effect.
- R6: A data read returns the oldest stored byte in bits 7:0 and removes it, so bytes come out in arrival order. Status bit 0 clears when the FIFO becomes empty. A data read on an empty FIFO returns 0.
- R7: Status bit 8 is 1 while the FIFO holds at least DEPTH/2 bytes. Status bit 10 is 1 while it holds DEPTH bytes.
- R8: A byte that arrives while the FIFO is full, with no pop in the same cycle, is dropped. This sets status bit 4 (overrun), which stays set until reset. FIFO occupancy never exceeds DEPTH.
- R9: A data write with control bit 1 set raises `tx_valid` in the next cycle, with `tx_data` equal to the write's bits 7:0. Both hold until `tx_ready` is seen high. A later write replaces a pending byte. With control bit 1 clear, a data write does nothing.
- R10: `irq` is high for exactly the cycle after a stored byte when control bit 2 is set, or after a sent byte when control bit 3 is set. At all other times `irq` is 0.
- R11: Writes to status are ignored. Status bits 1 and 2 always read 1, and bits 3, 5, 6, 7 and 9 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address; only bits 7:0 are decoded |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, valid in the access phase |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | A byte is waiting to be sent |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | The transmitter takes `tx_data` this cycle |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
On every cycle, the assertions check these behaviours:
- the bus handshake is constant;
- the FIFO never overfills;
- a disabled receiver leaves the FIFO untouched;
- a pending transmit byte stays stable until it is accepted;
- each interrupt pulse follows an enabled receive or transmit event;
- status reads show the fixed transmitter flags;
- an empty data read returns zero.

Only the bench's scenarios can show the following:
- the FIFO returns bytes in arrival order across a pointer wrap;
- the half and full flags change at the right occupancy;
- overrun is sticky;
- the offset alias and the unmapped offsets decode as required;
- the control register reads back over a full bit sweep.

// File: rtl/uart_front_pkg.sv
package uart_front_pkg;

    // Status bit positions
    localparam int ST_RX_AVAIL      = 0;
    localparam int ST_TX_SHIFT_IDLE = 1;
    localparam int ST_TX_Q_IDLE     = 2;
    localparam int ST_BREAK         = 3;
    localparam int ST_OVERRUN       = 4;
    localparam int ST_PAR_ERR       = 5;
    localparam int ST_FRAME_ERR     = 6;
    localparam int ST_TX_HALF       = 7;
    localparam int ST_RX_HALF       = 8;
    localparam int ST_TX_FULL       = 9;
    localparam int ST_RX_FULL       = 10;
    localparam int STATUS_W         = 32;

    // Control bit positions that this block acts on
    localparam int CT_RX_EN   = 0;
    localparam int CT_TX_EN   = 1;
    localparam int CT_RX_IE   = 2;
    localparam int CT_TX_IE   = 3;
    localparam int CTRL_BITS  = 13;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        SEL_DATA,
        SEL_STAT,
        SEL_CTRL,
        SEL_SCAL,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     rd_data;
        logic     wr_data;
        logic     wr_ctrl;
    } bus_cmd_t;

    typedef struct packed {
        logic avail;
        logic overrun;
        logic half;
        logic full;
    } rx_flags_t;

    function automatic reg_sel_e decode_offset(input logic [7:0] off);
        case (off)
            8'h00, 8'h03: return SEL_DATA;
            8'h04:        return SEL_STAT;
            8'h08:        return SEL_CTRL;
            8'h0C:        return SEL_SCAL;
            default:      return SEL_NONE;
        endcase
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(input rx_flags_t f);
        logic [STATUS_W-1:0] s;
        s                   = '0;
        s[ST_RX_AVAIL]      = f.avail;
        s[ST_TX_SHIFT_IDLE] = 1'b1;
        s[ST_TX_Q_IDLE]     = 1'b1;
        s[ST_BREAK]         = 1'b0;
        s[ST_OVERRUN]       = f.overrun;
        s[ST_PAR_ERR]       = 1'b0;
        s[ST_FRAME_ERR]     = 1'b0;
        s[ST_TX_HALF]       = 1'b0;
        s[ST_RX_HALF]       = f.half;
        s[ST_TX_FULL]       = 1'b0;
        s[ST_RX_FULL]       = f.full;
        return s;
    endfunction

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
    import uart_front_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [STATUS_W-1:0]           status,
    input  logic [CTRL_BITS-1:0]          ctrl,
    input  logic [BYTE_W-1:0]             head_byte,
    input  logic                          rx_nonempty,
    output bus_cmd_t                      cmd,
    output logic [DATA_W-1:0]             prdata
);
    logic access;
    reg_sel_e sel;

    assign access = psel && penable;
    assign sel    = decode_offset(paddr[7:0]);

    generate
        if (ADDR_W > 8) begin : g_hi_addr
            logic unused_hi;
            assign unused_hi = ^paddr[ADDR_W-1:8];
        end
    endgenerate

    always_comb begin
        cmd.sel     = sel;
        cmd.rd_data = access && !pwrite && (sel == SEL_DATA);
        cmd.wr_data = access &&  pwrite && (sel == SEL_DATA);
        cmd.wr_ctrl = access &&  pwrite && (sel == SEL_CTRL);
    end

    always_comb begin
        prdata = '0;
        case (sel)
            SEL_DATA: if (rx_nonempty) prdata = DATA_W'(head_byte);
            SEL_STAT: prdata = DATA_W'(status);
            SEL_CTRL: prdata = DATA_W'(ctrl);
            default:  prdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             accept,
    output logic             drop
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             full;
    logic             pop_eff;

    assign full    = (count == CNT_W'(DEPTH));
    assign pop_eff = pop_req && (count != '0);
    assign accept  = push_req && (!full || pop_eff);
    assign drop    = push_req && !accept;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept)  wr_ptr <= wr_ptr + 1'b1;
            if (pop_eff) rd_ptr <= rd_ptr + 1'b1;
            case ({accept, pop_eff})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_port.sv
module uart_tx_port
    import uart_front_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              send,
    input  logic [BYTE_W-1:0] send_byte,
    input  logic              tx_ready,
    input  logic              tx_irq_en,
    input  logic              rx_event,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (send) begin
            tx_valid <= 1'b1;
            tx_data  <= send_byte;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= rx_event || (send && tx_irq_en);
    end
endmodule

// File: rtl/apb_uart_front.sv
module apb_uart_front
    import uart_front_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    bus_cmd_t                cmd;
    logic [CTRL_BITS-1:0]    ctrl_q;
    logic                    overrun_q;
    logic [CNT_W-1:0]        rx_count;
    logic [BYTE_W-1:0]       rx_head;
    logic                    rx_push_req;
    logic                    rx_pop;
    logic                    rx_accept;
    logic                    rx_drop;
    logic                    tx_send;
    rx_flags_t               flags;
    logic [STATUS_W-1:0]     status;
    logic                    unused_wdata;

    assign pready       = 1'b1;
    assign pslverr      = 1'b0;
    assign unused_wdata = ^pwdata[DATA_W-1:CTRL_BITS];

    assign rx_push_req = rx_valid && ctrl_q[CT_RX_EN];
    assign rx_pop      = cmd.rd_data;
    assign tx_send     = cmd.wr_data && ctrl_q[CT_TX_EN];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            overrun_q <= 1'b0;
        end else begin
            if (cmd.wr_ctrl) ctrl_q <= pwdata[CTRL_BITS-1:0];
            if (rx_drop)     overrun_q <= 1'b1;
        end
    end

    always_comb begin
        flags.avail   = (rx_count != '0);
        flags.overrun = overrun_q;
        flags.half    = (rx_count >= CNT_W'(DEPTH / 2));
        flags.full    = (rx_count == CNT_W'(DEPTH));
        status        = pack_status(flags);
    end

    uart_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .paddr       (paddr),
        .status      (status),
        .ctrl        (ctrl_q),
        .head_byte   (rx_head),
        .rx_nonempty (flags.avail),
        .cmd         (cmd),
        .prdata      (prdata)
    );

    uart_rx_queue #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rxq (
        .clk      (clk),
        .rst      (rst),
        .push_req (rx_push_req),
        .pop_req  (rx_pop),
        .din      (rx_data),
        .head     (rx_head),
        .count    (rx_count),
        .accept   (rx_accept),
        .drop     (rx_drop)
    );

    uart_tx_port u_tx (
        .clk       (clk),
        .rst       (rst),
        .send      (tx_send),
        .send_byte (pwdata[BYTE_W-1:0]),
        .tx_ready  (tx_ready),
        .tx_irq_en (ctrl_q[CT_TX_IE]),
        .rx_event  (rx_accept && ctrl_q[CT_RX_IE]),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .irq       (irq)
    );
endmodule

// File: rtl/apb_uart_front_chk.sv
module apb_uart_front_chk
    import uart_front_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic [ADDR_W-1:0]    paddr,
    input logic [DATA_W-1:0]    prdata,
    input logic                 pready,
    input logic                 pslverr,
    input logic                 rx_valid,
    input logic                 tx_valid,
    input logic [7:0]           tx_data,
    input logic                 tx_ready,
    input logic                 irq,
    input logic [CTRL_BITS-1:0] ctrl_q,
    input logic [CNT_W-1:0]     rx_count,
    input logic                 rx_accept,
    input logic                 rx_pop,
    input logic                 tx_send
);
    logic rd_access;
    assign rd_access = psel && penable && !pwrite;

    p_bus_ready_r1: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);

    p_rx_hold_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !ctrl_q[CT_RX_EN] && !rx_pop |=> $stable(rx_count));

    p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
        rd_access && (paddr[7:0] == 8'h00 || paddr[7:0] == 8'h03) && rx_count == '0
        |-> prdata == '0);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CNT_W'(DEPTH));

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready && !tx_send |=> tx_valid && $stable(tx_data));

    p_rx_irq_r10: assert property (@(posedge clk) disable iff (rst)
        rx_accept && ctrl_q[CT_RX_IE] |=> irq);

    p_tx_irq_r10: assert property (@(posedge clk) disable iff (rst)
        tx_send && ctrl_q[CT_TX_IE] |=> irq && tx_valid);

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (rst)
        !((rx_accept && ctrl_q[CT_RX_IE]) || (tx_send && ctrl_q[CT_TX_IE])) |=> !irq);

    p_status_fixed_r11: assert property (@(posedge clk) disable iff (rst)
        rd_access && paddr[7:0] == 8'h04
        |-> prdata[2:1] == 2'b11 && prdata[3] == 1'b0 && prdata[7:5] == 3'b000
            && prdata[9] == 1'b0);
endmodule

bind apb_uart_front apb_uart_front_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .prdata    (prdata),
    .pready    (pready),
    .pslverr   (pslverr),
    .rx_valid  (rx_valid),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .irq       (irq),
    .ctrl_q    (ctrl_q),
    .rx_count  (rx_count),
    .rx_accept (rx_accept),
    .rx_pop    (rx_pop),
    .tx_send   (tx_send)
);

// File: tb/apb_uart_front_test.sv
`timescale 1ns/1ps
module apb_uart_front_test;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [DATA_W-1:0] pwdata = '0;
    logic [DATA_W-1:0] prdata;
    logic              pready, pslverr;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b0;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    apb_uart_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_status(input int cnt, input bit ovr);
        logic [31:0] s;
        s = 32'h6;
        if (cnt > 0)          s[0]  = 1'b1;
        if (ovr)              s[4]  = 1'b1;
        if (cnt >= DEPTH / 2) s[8]  = 1'b1;
        if (cnt == DEPTH)     s[10] = 1'b1;
        return s;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R3 reset state, R1 handshake
        apb_read(12'h004, r); check("R3 status", r, 32'h6);
        apb_read(12'h008, r); check("R3 control", r, 32'h0);
        apb_read(12'h000, r); check("R3 data empty", r, 32'h0);
        check("R3 irq", {31'b0, irq}, 32'h0);
        check("R3 tx_valid", {31'b0, tx_valid}, 32'h0);
        check("R1 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);

        // R4 control readback sweep
        for (int i = 0; i < 32; i++) begin
            apb_write(12'h008, 32'h1 << i);
            apb_read(12'h008, r);
            check("R4 control bit", r, (32'h1 << i) & 32'h1FFF);
        end
        apb_write(12'h008, 32'hFFFF_FFFF);
        apb_read(12'h008, r); check("R4 control all", r, 32'h1FFF);

        // R2 offset sweep with high address bits set
        apb_write(12'h008, 32'h1A5);
        for (int off = 0; off < 32; off++) begin
            logic [31:0] e;
            e = 32'h0;
            if (off == 4) e = 32'h6;
            if (off == 8) e = 32'h1A5;
            apb_read({4'hA, 8'(off)}, r);
            check($sformatf("R2 offset %0d", off), r, e);
        end

        // R5 receive disabled
        apb_write(12'h008, 32'h0);
        rx_push(8'h55);
        apb_read(12'h004, r); check("R5 rx disabled status", r, 32'h6);
        apb_read(12'h000, r); check("R5 rx disabled data", r, 32'h0);

        // R5 R7 fill the FIFO, no interrupt enable
        apb_write(12'h008, 32'h1);
        for (int k = 0; k < DEPTH; k++) begin
            rx_push(8'(8'h30 + k * 7));
            check("R10 no rx irq when disabled", {31'b0, irq}, 32'h0);
            apb_read(12'h004, r);
            check($sformatf("R7 status after %0d pushes", k + 1), r, exp_status(k + 1, 1'b0));
        end
        // R8 overrun
        rx_push(8'hEE);
        apb_read(12'h004, r); check("R8 overrun status", r, exp_status(DEPTH, 1'b1));
        // R6 drain in order
        for (int k = 0; k < DEPTH; k++) begin
            apb_read(k[0] ? 12'h003 : 12'h000, r);
            check($sformatf("R6 pop %0d", k), r, 32'(8'h30 + k * 7));
            apb_read(12'h004, r);
            check("R7 status draining", r, exp_status(DEPTH - 1 - k, 1'b1));
        end
        apb_read(12'h000, r); check("R6 empty read", r, 32'h0);
        apb_read(12'h004, r); check("R8 overrun sticky", r, 32'h16);

        // R6 wrap of pointers
        for (int k = 0; k < 3; k++) rx_push(8'(8'hC0 + k));
        for (int k = 0; k < 3; k++) begin
            apb_read(12'h000, r);
            check("R6 wrap order", r, 32'(8'hC0 + k));
        end

        // R11 status write ignored, R2 scaler
        apb_write(12'h004, 32'hFFFF_FFFF);
        apb_read(12'h004, r); check("R11 status write ignored", r, 32'h16);
        apb_write(12'h00C, 32'hFF);
        apb_read(12'h00C, r); check("R2 scaler zero", r, 32'h0);
        apb_read(12'h008, r); check("R2 scaler write no effect", r, 32'h1);

        // R10 receive interrupt
        apb_write(12'h008, 32'h5);
        rx_push(8'h9A);
        check("R10 rx irq pulse", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R10 rx irq one cycle", {31'b0, irq}, 32'h0);
        apb_read(12'h000, r); check("R5 stored byte", r, 32'h9A);

        // R9 transmit
        apb_write(12'h008, 32'h0);
        apb_write(12'h000, 32'hAB);
        check("R9 tx disabled", {31'b0, tx_valid}, 32'h0);
        apb_write(12'h008, 32'h2);
        apb_write(12'h000, 32'h1234A5);
        check("R9 tx valid", {31'b0, tx_valid}, 32'h1);
        check("R9 tx data", {24'b0, tx_data}, 32'hA5);
        check("R10 no tx irq", {31'b0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        check("R9 tx hold", {23'b0, tx_valid, tx_data}, 32'h1A5);
        tx_ready = 1'b1;
        @(negedge clk);
        check("R9 tx drained", {31'b0, tx_valid}, 32'h0);
        tx_ready = 1'b0;

        // R10 transmit interrupt via the offset 3 alias (R2)
        apb_write(12'h008, 32'hA);
        apb_write(12'h003, 32'h5C);
        check("R10 tx irq pulse", {31'b0, irq}, 32'h1);
        check("R2 alias tx data", {23'b0, tx_valid, tx_data}, 32'h15C);
        @(negedge clk);
        check("R10 tx irq one cycle", {31'b0, irq}, 32'h0);
        apb_write(12'h000, 32'h77);
        check("R9 replace pending", {24'b0, tx_data}, 32'h77);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;

        // R3 reset mid-run
        rx_push(8'h11);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        apb_read(12'h004, r); check("R3 status after reset", r, 32'h6);
        apb_read(12'h008, r); check("R3 control after reset", r, 32'h0);
        check("R1 pready after reset", {31'b0, pready}, 32'h1);

        done = 1'b1;
        finish_run();
    end
endmodule